// File: doc/BRIEF.md
# Transmit Holding Buffer Underrun Controller

This block sits between software, a transfer engine and the serial transmit shifter of a frame-based bus controller. It keeps one byte in a holding register and an "empty" flag for it. A byte written by the transfer engine marks the buffer full on its own. A byte written by the CPU does not: software must then clear the empty flag with a separate flag-clear write. When the shifter asks for a byte, the block either hands over the held byte or reports an underrun. An underrun sets an error flag and an underrun flag and parks the block in a wait state.

Each frame has a programmed byte length, and the block counts the bytes the shifter takes. A stale empty flag on the final byte of a full-length message can be tolerated: in that case the held byte is sent again and no error is raised. A control bit turns this tolerance off. The block comes out of reset stopped. It holds every register at its reset value until the run input is raised.

Top module: `txhold_ctrl`

## Requirements
- R1: While `mod_run` is 0, and after reset, the empty flag is 1, all other status outputs are 0, CPU and DMA writes have no effect, `frame_start` and `shf_load` are ignored, and `cpu_rdata` reads 0. Raising `mod_run` again finds control 0, length 0 and data 0.
- R2: A DMA write stores `dma_data` in the holding register and leaves `rdy_flag` at 0 on the following cycle.
- R3: A CPU write to address 0 stores the byte and leaves `rdy_flag` unchanged. A CPU write to address 3 with bit 0 set clears `rdy_flag`. Address 0 reads back the held byte.
- R4: When a DMA write meets a CPU flag-clear write, `rdy_flag` ends at 0. When a DMA write meets a CPU data write, the DMA byte is the one stored.
- R5: A `shf_load` during an active frame with `rdy_flag` 0 raises `shf_valid` in the same cycle with `shf_data` equal to the held byte. `rdy_flag` is 1 on the following cycle.
- R6: A `shf_load` with `rdy_flag` 1 on any byte other than the last of the frame is an underrun. No `shf_valid` is given, and `txerr_flag`, `uerr_flag` and `waiting` become 1 on the next cycle. This holds whatever the value of control bit 0.
- R7: With control bit 0 (address 1) at 0, a `shf_load` on the last byte of the frame (bytes taken plus one equals length) with `rdy_flag` 1 sends the held byte normally, with no error.
- R8: With control bit 0 at 1, the same last-byte case is an underrun, as in R6.
- R9: While `waiting` is 1, loads are ignored. A CPU write to address 3 with bit 1 set clears `txerr_flag`, `uerr_flag` and `waiting`. A `frame_start` clears `waiting` only.
- R10: `frame_start` latches the length from address 2 (8 bits) and restarts the byte count. Once the count reaches the length, `msg_done` is 1 and further loads are ignored.
- R11: When `shf_load` and a DMA write fall in the same cycle, the shifter takes the old byte, the new byte is stored, and `rdy_flag` ends at 0.
- R12: Status at address 3 reads bit 0 empty, bit 1 transmit error, bit 2 underrun, bit 3 waiting and bit 4 message done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_run | input | 1 | 1 releases the module from its stopped state |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 2 | Register address: 0 data, 1 control, 2 length, 3 flags |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register read data (combinational) |
| dma_wr | input | 1 | Transfer-engine write strobe |
| dma_data | input | 8 | Transfer-engine byte |
| frame_start | input | 1 | Starts a new frame |
| shf_load | input | 1 | Shifter requests the next byte |
| shf_valid | output | 1 | Byte handed to the shifter this cycle |
| shf_data | output | 8 | Byte handed to the shifter |
| rdy_flag | output | 1 | Holding register is empty |
| txerr_flag | output | 1 | Transmit error |
| uerr_flag | output | 1 | Underrun error |
| waiting | output | 1 | Parked after an underrun |
| msg_done | output | 1 | All bytes of the frame taken |

## Verification
Two functions can land on the same clock edge. In one, the shifter takes a byte while the transfer engine writes the next one. In the other, a transfer-engine write meets a CPU flag clear or a CPU data write. The bench drives these strobes together in a single cycle. A scoreboard checks that the shifter received the byte held before the edge. Register reads afterwards check that the new byte was stored and that the empty flag stayed at 0.

// File: rtl/txh_pkg.sv
package txh_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_LEN  = 2'd2,
    REG_FLAG = 2'd3
  } txh_reg_e;

  // status bit positions at REG_FLAG
  localparam int ST_RDY  = 0;
  localparam int ST_TXE  = 1;
  localparam int ST_UE   = 2;
  localparam int ST_WAIT = 3;
  localparam int ST_DONE = 4;

  // flag-clear command bits at REG_FLAG
  localparam int CLR_RDY = 0;
  localparam int CLR_ERR = 1;

  // control bit: strict last-byte checking
  localparam int CT_STRICT = 0;

  typedef enum logic [1:0] {
    LD_NONE,
    LD_SEND,
    LD_EXEMPT,
    LD_UNDER
  } ld_kind_e;

  // true when the next load is the final byte of the frame
  function automatic logic final_slot(input int unsigned sent, input int unsigned total);
    return (sent + 1) == total;
  endfunction

  // outcome of a shifter request
  function automatic ld_kind_e judge_load(input logic req, input logic empty,
                                          input logic last, input logic strict);
    if (!req)            return LD_NONE;
    if (!empty)          return LD_SEND;
    if (last && !strict) return LD_EXEMPT;
    return LD_UNDER;
  endfunction

endpackage

// File: rtl/txh_regs.sv
module txh_regs
  import txh_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              cpu_wr_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              strict_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              data_we_o,
  output logic              rdy_clr_o,
  output logic              err_clr_o
);

  logic wr_ok;
  logic ctrl_we, len_we, flag_we;

  assign wr_ok     = run_i & cpu_wr_i;
  assign data_we_o = wr_ok && (cpu_addr_i == REG_DATA);
  assign ctrl_we   = wr_ok && (cpu_addr_i == REG_CTRL);
  assign len_we    = wr_ok && (cpu_addr_i == REG_LEN);
  assign flag_we   = wr_ok && (cpu_addr_i == REG_FLAG);
  assign rdy_clr_o = flag_we & cpu_wdata_i[CLR_RDY];
  assign err_clr_o = flag_we & cpu_wdata_i[CLR_ERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strict_o <= 1'b0;
      len_o    <= '0;
    end else if (!run_i) begin
      strict_o <= 1'b0;
      len_o    <= '0;
    end else begin
      if (ctrl_we) strict_o <= cpu_wdata_i[CT_STRICT];
      if (len_we)  len_o    <= cpu_wdata_i[LEN_W-1:0];
    end
  end

endmodule

// File: rtl/txh_hold.sv
module txh_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              dma_wr_i,
  input  logic [DATA_W-1:0] dma_data_i,
  input  logic              cpu_we_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic              rdy_clr_i,
  input  logic              take_i,
  output logic              dma_evt_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              rdy_o
);

  assign dma_evt_o = run_i & dma_wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_o <= '0;
      rdy_o  <= 1'b1;
    end else if (!run_i) begin
      hold_o <= '0;
      rdy_o  <= 1'b1;
    end else begin
      // transfer-engine byte has precedence over a CPU byte
      if (dma_evt_o)     hold_o <= dma_data_i;
      else if (cpu_we_i) hold_o <= cpu_data_i;
      // engine write marks full; shifter take marks empty; CPU clear last
      if (dma_evt_o)      rdy_o <= 1'b0;
      else if (take_i)    rdy_o <= 1'b1;
      else if (rdy_clr_i) rdy_o <= 1'b0;
    end
  end

endmodule

// File: rtl/txh_seq.sv
module txh_seq
  import txh_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             frame_start_i,
  input  logic             shf_load_i,
  input  logic             rdy_i,
  input  logic             strict_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             err_clr_i,
  output logic             take_o,
  output logic             under_o,
  output logic             txe_o,
  output logic             ue_o,
  output logic             wait_o,
  output logic             done_o
);

  logic [LEN_W-1:0] cnt_q, flen_q;
  logic             active_q;
  logic             fs, req, is_last;
  ld_kind_e         kind;

  assign fs      = run_i & frame_start_i;
  assign req     = run_i & shf_load_i & active_q & ~wait_o & ~fs;
  assign is_last = final_slot(32'(cnt_q), 32'(flen_q));
  assign kind    = judge_load(req, rdy_i, is_last, strict_i);
  assign take_o  = (kind == LD_SEND) || (kind == LD_EXEMPT);
  assign under_o = (kind == LD_UNDER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      flen_q   <= '0;
      active_q <= 1'b0;
      wait_o   <= 1'b0;
      txe_o    <= 1'b0;
      ue_o     <= 1'b0;
      done_o   <= 1'b0;
    end else if (!run_i) begin
      cnt_q    <= '0;
      flen_q   <= '0;
      active_q <= 1'b0;
      wait_o   <= 1'b0;
      txe_o    <= 1'b0;
      ue_o     <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      if (err_clr_i) begin
        txe_o  <= 1'b0;
        ue_o   <= 1'b0;
        wait_o <= 1'b0;
      end
      if (fs) begin
        cnt_q    <= '0;
        flen_q   <= len_i;
        active_q <= (len_i != '0);
        done_o   <= (len_i == '0);
        wait_o   <= 1'b0;
      end else if (take_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (is_last) begin
          active_q <= 1'b0;
          done_o   <= 1'b1;
        end
      end else if (under_o) begin
        active_q <= 1'b0;
        wait_o   <= 1'b1;
        txe_o    <= 1'b1;
        ue_o     <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/txhold_ctrl.sv
module txhold_ctrl
  import txh_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_run,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] dma_data,
  input  logic              frame_start,
  input  logic              shf_load,
  output logic              shf_valid,
  output logic [DATA_W-1:0] shf_data,
  output logic              rdy_flag,
  output logic              txerr_flag,
  output logic              uerr_flag,
  output logic              waiting,
  output logic              msg_done
);

  // named internal events, visible to the bound checker
  logic              strict_w;
  logic [LEN_W-1:0]  len_w;
  logic              data_we_w, rdy_clr_w, err_clr_w;
  logic              take_w, under_w, dma_evt_w;
  logic [DATA_W-1:0] hold_w;
  logic [DATA_W-1:0] stat_w;

  txh_regs #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (mod_run),
    .cpu_wr_i   (cpu_wr),
    .cpu_addr_i (cpu_addr),
    .cpu_wdata_i(cpu_wdata),
    .strict_o   (strict_w),
    .len_o      (len_w),
    .data_we_o  (data_we_w),
    .rdy_clr_o  (rdy_clr_w),
    .err_clr_o  (err_clr_w)
  );

  txh_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (mod_run),
    .dma_wr_i  (dma_wr),
    .dma_data_i(dma_data),
    .cpu_we_i  (data_we_w),
    .cpu_data_i(cpu_wdata),
    .rdy_clr_i (rdy_clr_w),
    .take_i    (take_w),
    .dma_evt_o (dma_evt_w),
    .hold_o    (hold_w),
    .rdy_o     (rdy_flag)
  );

  txh_seq #(.LEN_W(LEN_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (mod_run),
    .frame_start_i(frame_start),
    .shf_load_i   (shf_load),
    .rdy_i        (rdy_flag),
    .strict_i     (strict_w),
    .len_i        (len_w),
    .err_clr_i    (err_clr_w),
    .take_o       (take_w),
    .under_o      (under_w),
    .txe_o        (txerr_flag),
    .ue_o         (uerr_flag),
    .wait_o       (waiting),
    .done_o       (msg_done)
  );

  assign shf_valid = take_w;
  assign shf_data  = take_w ? hold_w : '0;

  always_comb begin
    stat_w          = '0;
    stat_w[ST_RDY]  = rdy_flag;
    stat_w[ST_TXE]  = txerr_flag;
    stat_w[ST_UE]   = uerr_flag;
    stat_w[ST_WAIT] = waiting;
    stat_w[ST_DONE] = msg_done;
  end

  always_comb begin
    cpu_rdata = '0;
    if (mod_run) begin
      case (txh_reg_e'(cpu_addr))
        REG_DATA: cpu_rdata = hold_w;
        REG_CTRL: cpu_rdata[CT_STRICT] = strict_w;
        REG_LEN:  cpu_rdata[LEN_W-1:0] = len_w;
        REG_FLAG: cpu_rdata = stat_w;
        default:  cpu_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/txh_ctrl_chk.sv
module txh_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mod_run,
  input logic       cpu_wr,
  input logic [1:0] cpu_addr,
  input logic       dma_wr,
  input logic       shf_load,
  input logic       shf_valid,
  input logic       rdy_flag,
  input logic       txerr_flag,
  input logic       uerr_flag,
  input logic       waiting,
  input logic       msg_done,
  input logic       take_w,
  input logic       under_w,
  input logic       dma_evt_w
);

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_run |=> rdy_flag && !txerr_flag && !uerr_flag && !waiting && !msg_done);

  // R2
  dma_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_evt_w |=> !rdy_flag);

  // R3
  cpu_byte_keeps_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_run && cpu_wr && cpu_addr == 2'd0 && !dma_wr && !take_w) |=> $stable(rdy_flag));

  // R5
  take_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && !dma_evt_w) |=> rdy_flag);

  // R5
  valid_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shf_valid |-> shf_load);

  // R6
  underrun_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    under_w |=> txerr_flag && uerr_flag && waiting);

  // R9
  wait_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !shf_valid);

  // R10
  done_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> !shf_valid);

  // R11
  collide_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && dma_evt_w) |=> !rdy_flag);

endmodule

bind txhold_ctrl txh_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mod_run   (mod_run),
  .cpu_wr    (cpu_wr),
  .cpu_addr  (cpu_addr),
  .dma_wr    (dma_wr),
  .shf_load  (shf_load),
  .shf_valid (shf_valid),
  .rdy_flag  (rdy_flag),
  .txerr_flag(txerr_flag),
  .uerr_flag (uerr_flag),
  .waiting   (waiting),
  .msg_done  (msg_done),
  .take_w    (take_w),
  .under_w   (under_w),
  .dma_evt_w (dma_evt_w)
);

// File: tb/txhold_ctrl_test.sv
module txhold_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mod_run = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic       dma_wr = 1'b0;
  logic [7:0] dma_data = 8'd0;
  logic       frame_start = 1'b0;
  logic       shf_load = 1'b0;
  logic       shf_valid;
  logic [7:0] shf_data;
  logic       rdy_flag, txerr_flag, uerr_flag, waiting, msg_done;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] expq[$];

  txhold_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mod_run(mod_run),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dma_wr(dma_wr), .dma_data(dma_data), .frame_start(frame_start),
    .shf_load(shf_load), .shf_valid(shf_valid), .shf_data(shf_data),
    .rdy_flag(rdy_flag), .txerr_flag(txerr_flag), .uerr_flag(uerr_flag),
    .waiting(waiting), .msg_done(msg_done)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: mid low phase, compares each handed-over byte
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (shf_valid) begin
        total++;
        if (expq.size() == 0) begin
          bad++;
          $display("FAIL R5/R9/R10 unexpected byte: actual=%0h expected=none", shf_data);
        end else begin
          logic [7:0] e;
          e = expq.pop_front();
          if (shf_data != e) begin
            bad++;
            $display("FAIL R5 shifter byte: actual=%0h expected=%0h", shf_data, e);
          end
        end
      end
    end
  end

  // one-cycle drive of any combination of strobes
  task automatic drive(input bit cw, input logic [1:0] a, input logic [7:0] wd,
                       input bit dw, input logic [7:0] dd, input bit fs,
                       input bit ld, input bit exp_ok, input logic [7:0] exp_b);
    @(negedge clk);
    cpu_wr = cw; cpu_addr = a; cpu_wdata = wd;
    dma_wr = dw; dma_data = dd;
    frame_start = fs; shf_load = ld;
    if (exp_ok) expq.push_back(exp_b);
    @(negedge clk);
    cpu_wr = 1'b0; dma_wr = 1'b0; frame_start = 1'b0; shf_load = 1'b0;
    #6;
  endtask

  task automatic cpu_w(input logic [1:0] a, input logic [7:0] d);
    drive(1, a, d, 0, 8'h00, 0, 0, 0, 8'h00);
  endtask
  task automatic dma_w(input logic [7:0] d);
    drive(0, 2'd0, 8'h00, 1, d, 0, 0, 0, 8'h00);
  endtask
  task automatic fstart();
    drive(0, 2'd0, 8'h00, 0, 8'h00, 1, 0, 0, 8'h00);
  endtask
  task automatic load(input bit ok, input logic [7:0] b);
    drive(0, 2'd0, 8'h00, 0, 8'h00, 0, 1, ok, b);
  endtask
  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    cpu_addr = a;
    #1;
    v = cpu_rdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R1 reset / stopped state
    chk("R1 rdy after reset", rdy_flag, 1);
    chk("R1 errors after reset", {txerr_flag, uerr_flag, waiting, msg_done}, 0);
    rd(2'd3, v); chk("R1 read while stopped", v, 0);
    cpu_w(2'd2, 8'd5);
    dma_w(8'h55);
    chk("R1 dma ignored while stopped", rdy_flag, 1);
    drive(0, 2'd0, 8'h00, 0, 8'h00, 1, 1, 0, 8'h00);
    chk("R1 load ignored while stopped", msg_done, 0);
    mod_run = 1'b1;
    @(negedge clk); #5;
    rd(2'd2, v); chk("R1 length untouched", v, 0);
    rd(2'd0, v); chk("R1 data untouched", v, 0);

    // R3 CPU data write keeps flag; explicit clear
    cpu_w(2'd0, 8'hA1);
    chk("R3 cpu write keeps rdy", rdy_flag, 1);
    rd(2'd0, v); chk("R3 data readback", v, 8'hA1);
    cpu_w(2'd3, 8'h01);
    chk("R3 flag clear", rdy_flag, 0);
    rd(2'd3, v); chk("R12 status rdy=0", v, 8'h00);

    // R5 / R7 / R10 full-length frame with exemption
    cpu_w(2'd2, 8'd3);
    fstart();
    load(1, 8'hA1);
    chk("R5 rdy after take", rdy_flag, 1);
    dma_w(8'hB2);
    chk("R2 dma clears rdy", rdy_flag, 0);
    load(1, 8'hB2);
    load(1, 8'hB2);
    chk("R7 no error on stale last", {txerr_flag, uerr_flag, waiting}, 0);
    chk("R10 message done", msg_done, 1);
    rd(2'd3, v); chk("R12 status done+rdy", v, 8'h11);
    load(0, 8'h00);
    chk("R10 load after done ignored", {msg_done, txerr_flag}, 2'b10);

    // R8 strict last byte
    cpu_w(2'd1, 8'h01);
    cpu_w(2'd2, 8'd2);
    fstart();
    chk("R10 frame start clears done", msg_done, 0);
    dma_w(8'hC3);
    load(1, 8'hC3);
    load(0, 8'h00);
    chk("R8 strict last underrun", {txerr_flag, uerr_flag, waiting}, 3'b111);
    rd(2'd3, v); chk("R12 status underrun", v, 8'h0F);
    load(0, 8'h00);
    chk("R9 load ignored in wait", waiting, 1);
    cpu_w(2'd3, 8'h02);
    chk("R9 error clear", {txerr_flag, uerr_flag, waiting}, 0);

    // R6 short supply, exemption off irrelevant
    cpu_w(2'd1, 8'h00);
    cpu_w(2'd2, 8'd4);
    fstart();
    dma_w(8'hD4);
    load(1, 8'hD4);
    load(0, 8'h00);
    chk("R6 mid-frame underrun", {txerr_flag, uerr_flag, waiting}, 3'b111);
    fstart();
    chk("R9 frame start leaves wait", {txerr_flag, uerr_flag, waiting}, 3'b110);
    cpu_w(2'd3, 8'h02);
    chk("R9 clear after restart", {txerr_flag, uerr_flag}, 0);

    // R4 collisions at the holding register
    chk("R4 precondition rdy", rdy_flag, 1);
    drive(1, 2'd3, 8'h01, 1, 8'hE5, 0, 0, 0, 8'h00);
    chk("R4 dma vs clear rdy", rdy_flag, 0);
    rd(2'd0, v); chk("R4 dma vs clear data", v, 8'hE5);
    drive(1, 2'd0, 8'h77, 1, 8'h66, 0, 0, 0, 8'h00);
    rd(2'd0, v); chk("R4 dma beats cpu data", v, 8'h66);

    // R11 shifter take meets DMA write
    cpu_w(2'd2, 8'd2);
    fstart();
    drive(0, 2'd0, 8'h00, 1, 8'hF7, 0, 1, 1, 8'h66);
    chk("R11 rdy stays full", rdy_flag, 0);
    rd(2'd0, v); chk("R11 new byte stored", v, 8'hF7);
    load(1, 8'hF7);
    chk("R10 done after second", msg_done, 1);
    chk("R5 rdy after final", rdy_flag, 1);

    // R1 stop again
    cpu_w(2'd1, 8'h01);
    mod_run = 1'b0;
    @(negedge clk); #5;
    chk("R1 stop resets", {rdy_flag, msg_done, waiting}, 3'b100);
    rd(2'd1, v); chk("R1 read zero when stopped", v, 0);
    mod_run = 1'b1;
    @(negedge clk); #5;
    rd(2'd1, v); chk("R1 control reset", v, 0);

    chk("R5 scoreboard drained", expq.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule